// File: doc/BRIEF.md
# Host Register Access Interface

This block connects a narrow asynchronous host bus (16-bit data, 3-bit address, chip enable, read and write strobes) to a wide 32-bit internal register space with a 16-bit index. The host reaches only four direct addresses. Two of them stage the halves of a 32-bit write word. A third takes an internal index and starts a core write of the staged word. The fourth works in two ways. A write to it picks an internal index for readback. A read from it returns a status word.

When a readback index is selected, the block reads the internal item once and holds the full 32-bit result. The host then collects the low half at direct address 0 and the high half at direct address 1, and may read either half as often as it likes. Reads at direct address 2 go to a separate output-data stream. Each finished read there produces one advance pulse toward that stream. Write strobes, and the address-2 read strobe, are synchronized into the core clock before any core access is made.

One index range is protected (a coefficient store). Accesses to it are carried out only while a hold flag is set. The block keeps a copy of that flag from the writes to a control index. A protected access made while the flag is clear is dropped. A dropped read returns zero.

Top module: `hbus_regif`

## Requirements
- R1: After reset, status, both readback halves and the staged write word read as zero, and no core strobe is asserted.
- R2: A write at direct address 0 stages bits 15:0 and a write at direct address 1 stages bits 31:16 of the write word. A write at direct address 2 issues exactly one single-cycle core write to the index on the data bus, carrying the staged word.
- R3: A write at direct address 3 issues exactly one core read of the index on the data bus. After that, a read at direct address 0 returns bits 15:0 of the result and a read at direct address 1 returns bits 31:16.
- R4: The readback value is captured once, at selection. Repeated reads return the same pair, even if the internal item changes later. A new selection is needed to see the change.
- R5: A read at direct address 3 returns the status word: bit 0 is the hold flag, bit 1 is core-access-in-flight, bit 2 is last-access-denied, bit 3 is the output-data-available input, and the other bits are zero.
- R6: A read at direct address 2 returns the output-data input and causes no core access. Each such read produces exactly one single-cycle advance pulse after the read strobe ends.
- R7: A host write strobe reaches the core through a synchronizer. The core write strobe rises exactly SYNC_STAGES+1 core clocks after the host strobe rises, and never earlier.
- R8: While the hold flag is clear, a write to the protected range (index & 0xFF00 == 0x0100) issues no core write, leaves the stored value unchanged and sets status bit 2. The next granted access clears bit 2.
- R9: While the hold flag is clear, selecting a protected index issues no core read, and the readback returns zero.
- R10: While the hold flag is set, protected writes and reads proceed like any other access.
- R11: A granted core write to index 0x000A sets the hold flag to bit 0 of the written word.
- R12: With chip enable low, host writes have no effect, and host reads with chip enable or read strobe low return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| host_ce | input | 1 | Host chip enable |
| host_wr | input | 1 | Host write strobe (asynchronous) |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Direct address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| core_addr | output | 16 | Internal index of the core access |
| core_wdata | output | 32 | Core write data |
| core_we | output | 1 | Core write strobe, one cycle |
| core_re | output | 1 | Core read strobe, one cycle |
| core_rdata | input | 32 | Core read data, valid RD_LAT cycles after core_re |
| ro_data | input | 16 | Output-data stream word |
| ro_avail | input | 1 | Output-data stream has data |
| ro_pop | output | 1 | Advance pulse for the output-data stream |

## Verification
The assertions check on every cycle the properties that can be seen locally. Core write and read strobes never overlap and never last more than one cycle. Each core strobe follows a synchronized host event of the right kind. Protected indices reach the core only while the hold flag is set. The readback latch changes only on a capture event, and the advance pulse is a single cycle. Some behaviours show only in the bench scenarios: the exact synchronizer delay, the split of the 32-bit word across two addresses, the readback still showing the old value after the internal item changes, dropped protected writes leaving stored data unchanged, and the decoding of the status bits.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  // direct (host-visible) address decode
  typedef enum logic [2:0] {
    DA_STAGE_LO = 3'd0,
    DA_STAGE_HI = 3'd1,
    DA_STREAM   = 3'd2,
    DA_SELECT   = 3'd3
  } daddr_e;

  typedef struct packed {
    logic avail;
    logic denied;
    logic busy;
    logic hold;
  } stat_t;

  // true when an internal index falls in the protected window
  function automatic logic in_window(input logic [15:0] idx,
                                     input logic [15:0] base,
                                     input logic [15:0] mask);
    return (idx & mask) == base;
  endfunction

  // access is granted when outside the window or the hold flag is set
  function automatic logic granted(input logic [15:0] idx,
                                   input logic [15:0] base,
                                   input logic [15:0] mask,
                                   input logic hold);
    return !in_window(idx, base, mask) || hold;
  endfunction

endpackage

// File: rtl/hbus_edge_sync.sv
module hbus_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/hbus_host_latch.sv
module hbus_host_latch
  import hbus_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [2:0]    host_addr,
  input  logic [HW-1:0] host_wdata,
  output logic [2*HW-1:0] stage_word,
  output logic          cmd_wr,
  output logic          cmd_sel,
  output logic [HW-1:0] cmd_idx
);
  logic [HW-1:0] stage_lo, stage_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo <= '0;
      stage_hi <= '0;
    end else if (wr_evt) begin
      if (host_addr == DA_STAGE_LO) stage_lo <= host_wdata;
      if (host_addr == DA_STAGE_HI) stage_hi <= host_wdata;
    end
  end

  assign stage_word = {stage_hi, stage_lo};
  assign cmd_wr     = wr_evt && (host_addr == DA_STREAM);
  assign cmd_sel    = wr_evt && (host_addr == DA_SELECT);
  assign cmd_idx    = host_wdata;
endmodule

// File: rtl/hbus_core_seq.sv
module hbus_core_seq
  import hbus_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter int          RD_LAT    = 1,
  parameter logic [15:0] PROT_BASE = 16'h0100,
  parameter logic [15:0] PROT_MASK = 16'hFF00,
  parameter logic [15:0] HOLD_IDX  = 16'h000A,
  parameter int          HOLD_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_sel,
  input  logic [AW-1:0] cmd_idx,
  input  logic [DW-1:0] stage_word,
  input  logic [DW-1:0] core_rdata,
  output logic [AW-1:0] core_addr,
  output logic [DW-1:0] core_wdata,
  output logic          core_we,
  output logic          core_re,
  output logic [DW-1:0] rd_latch,
  output logic          hold,
  output logic          denied,
  output logic          busy,
  output logic          cap_evt
);
  logic [RD_LAT-1:0] pend;
  logic              allow;
  logic              deny_rd;

  assign allow   = granted(cmd_idx, PROT_BASE, PROT_MASK, hold);
  assign deny_rd = cmd_sel && !allow;
  assign cap_evt = pend[RD_LAT-1] || deny_rd;
  assign busy    = core_re || (|pend);

  generate
    if (RD_LAT == 1) begin : g_pend1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= core_re;
      end
    end else begin : g_pendn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= {pend[RD_LAT-2:0], core_re};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_addr  <= '0;
      core_wdata <= '0;
      core_we    <= 1'b0;
      core_re    <= 1'b0;
      rd_latch   <= '0;
      hold       <= 1'b0;
      denied     <= 1'b0;
    end else begin
      core_we <= 1'b0;
      core_re <= 1'b0;
      if (cmd_wr) begin
        if (allow) begin
          core_we    <= 1'b1;
          core_addr  <= cmd_idx;
          core_wdata <= stage_word;
          denied     <= 1'b0;
          if (cmd_idx == HOLD_IDX) hold <= stage_word[HOLD_BIT];
        end else begin
          denied <= 1'b1;
        end
      end
      if (cmd_sel) begin
        if (allow) begin
          core_re   <= 1'b1;
          core_addr <= cmd_idx;
          denied    <= 1'b0;
        end else begin
          denied <= 1'b1;
        end
      end
      if (deny_rd)             rd_latch <= '0;
      else if (pend[RD_LAT-1]) rd_latch <= core_rdata;
    end
  end
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
  import hbus_pkg::*;
#(
  parameter int          HW          = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          RD_LAT      = 1,
  parameter logic [15:0] PROT_BASE   = 16'h0100,
  parameter logic [15:0] PROT_MASK   = 16'hFF00,
  parameter logic [15:0] HOLD_IDX    = 16'h000A,
  parameter int          HOLD_BIT    = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_ce,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [2:0]    host_addr,
  input  logic [HW-1:0] host_wdata,
  output logic [HW-1:0] host_rdata,
  output logic [HW-1:0] core_addr,
  output logic [2*HW-1:0] core_wdata,
  output logic          core_we,
  output logic          core_re,
  input  logic [2*HW-1:0] core_rdata,
  input  logic [HW-1:0] ro_data,
  input  logic          ro_avail,
  output logic          ro_pop
);
  localparam int DW = 2 * HW;

  logic          wr_lvl, wr_evt, wr_fall;
  logic          rd_lvl, rd_rise, rd_fall;
  logic          cmd_wr, cmd_sel;
  logic [HW-1:0] cmd_idx;
  logic [DW-1:0] stage_word;
  logic [DW-1:0] rd_latch;
  logic          hold, denied, busy, cap_evt;
  stat_t         stat;

  hbus_edge_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst_n(rst_n), .async_in(host_ce & host_wr),
    .level(wr_lvl), .rise(wr_evt), .fall(wr_fall));

  hbus_edge_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n),
    .async_in(host_ce & host_rd & (host_addr == DA_STREAM)),
    .level(rd_lvl), .rise(rd_rise), .fall(rd_fall));

  hbus_host_latch #(.HW(HW)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .host_addr(host_addr),
    .host_wdata(host_wdata), .stage_word(stage_word),
    .cmd_wr(cmd_wr), .cmd_sel(cmd_sel), .cmd_idx(cmd_idx));

  hbus_core_seq #(
    .AW(HW), .DW(DW), .RD_LAT(RD_LAT), .PROT_BASE(PROT_BASE),
    .PROT_MASK(PROT_MASK), .HOLD_IDX(HOLD_IDX), .HOLD_BIT(HOLD_BIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
    .cmd_idx(cmd_idx), .stage_word(stage_word), .core_rdata(core_rdata),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_we(core_we),
    .core_re(core_re), .rd_latch(rd_latch), .hold(hold),
    .denied(denied), .busy(busy), .cap_evt(cap_evt));

  // advance pulse when a stream read finishes (synchronized trailing edge)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ro_pop <= 1'b0;
    else        ro_pop <= rd_fall;
  end

  assign stat = '{avail: ro_avail, denied: denied, busy: busy, hold: hold};

  always_comb begin
    host_rdata = '0;
    if (host_ce && host_rd) begin
      case (host_addr)
        DA_STAGE_LO: host_rdata = rd_latch[HW-1:0];
        DA_STAGE_HI: host_rdata = rd_latch[DW-1:HW];
        DA_STREAM:   host_rdata = ro_data;
        DA_SELECT:   host_rdata = HW'(stat);
        default:     host_rdata = '0;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, wr_lvl, wr_fall, rd_lvl, rd_rise};
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk #(
  parameter logic [15:0] PROT_BASE = 16'h0100,
  parameter logic [15:0] PROT_MASK = 16'hFF00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_evt,
  input logic        cmd_wr,
  input logic        cmd_sel,
  input logic        cap_evt,
  input logic [31:0] rd_latch,
  input logic        hold,
  input logic [15:0] core_addr,
  input logic        core_we,
  input logic        core_re,
  input logic        ro_pop
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(core_we && core_re)); // R2
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) core_we |=> !core_we); // R2
  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) core_re |=> !core_re); // R3
  AST_WE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n) core_we |-> $past(cmd_wr)); // R7
  AST_RE_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n) core_re |-> $past(cmd_sel)); // R3
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_evt |=> !wr_evt); // R7
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !cap_evt |=> $stable(rd_latch)); // R4
  AST_PROT_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && ((core_addr & PROT_MASK) == PROT_BASE)) |-> hold); // R8
  AST_PROT_RE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_re && ((core_addr & PROT_MASK) == PROT_BASE)) |-> hold); // R9
  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ro_pop |=> !ro_pop); // R6
endmodule

bind hbus_regif hbus_regif_chk #(.PROT_BASE(PROT_BASE), .PROT_MASK(PROT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
  .cap_evt(cap_evt), .rd_latch(rd_latch), .hold(hold), .core_addr(core_addr),
  .core_we(core_we), .core_re(core_re), .ro_pop(ro_pop));

// File: tb/hbus_regif_bench.sv
module hbus_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_ce = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic [15:0] core_addr;
  logic [31:0] core_wdata;
  logic        core_we, core_re;
  logic [31:0] core_rdata;
  logic [15:0] ro_data = 16'hBEEF;
  logic        ro_avail = 1'b0;
  logic        ro_pop;

  int n_cmp = 0, n_bad = 0;
  int we_cnt = 0, re_cnt = 0, pop_cnt = 0;
  logic [15:0] last_we_addr = '0;
  logic [31:0] last_we_data = '0;
  bit done = 0;

  always #4 clk = ~clk;

  hbus_regif u_hbus_regif (
    .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_we(core_we), .core_re(core_re), .core_rdata(core_rdata),
    .ro_data(ro_data), .ro_avail(ro_avail), .ro_pop(ro_pop));

  // simple internal register file, one cycle read latency
  logic [31:0] rf [512];
  logic [31:0] rf_q = '0;
  always_ff @(posedge clk) begin
    if (core_we) rf[core_addr[8:0]] <= core_wdata;
    if (core_re) rf_q <= rf[core_addr[8:0]];
  end
  assign core_rdata = rf_q;

  always @(negedge clk) begin
    if (core_we) begin we_cnt++; last_we_addr = core_addr; last_we_data = core_wdata; end
    if (core_re) re_cnt++;
    if (ro_pop)  pop_cnt++;
  end

  function automatic logic [31:0] pat(input int a, input int salt);
    return 32'h1357_2468 ^ (32'(a) * 32'h0001_0003) ^ (32'(salt) * 32'h0F0F_0101);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [15:0] d, input logic ce = 1'b1);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_ce = ce; host_wr = 1'b1;
    repeat (6) @(negedge clk);
    host_wr = 1'b0;
    repeat (4) @(negedge clk);
    host_ce = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_ce = 1'b1; host_rd = 1'b1;
    repeat (2) @(negedge clk);
    d = host_rdata;
    host_rd = 1'b0;
    repeat (6) @(negedge clk);
    host_ce = 1'b0;
  endtask

  task automatic core_write(input logic [15:0] idx, input logic [31:0] v);
    hwrite(3'd0, v[15:0]);
    hwrite(3'd1, v[31:16]);
    hwrite(3'd2, idx);
  endtask

  task automatic core_read(input logic [15:0] idx, output logic [31:0] v);
    logic [15:0] lo, hi;
    hwrite(3'd3, idx);
    hread(3'd0, lo);
    hread(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] r16;
    logic [31:0] r32;
    int we0, re0, pop0;
    for (int i = 0; i < 512; i++) rf[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    hread(3'd3, r16); chk("R1 status", 32'(r16), 0);
    hread(3'd0, r16); chk("R1 readback lo", 32'(r16), 0);
    hread(3'd1, r16); chk("R1 readback hi", 32'(r16), 0);
    chk("R1 no strobes", 32'(we_cnt + re_cnt), 0);
    hwrite(3'd2, 16'h0002);
    chk("R1 staged word zero", last_we_data, 0);

    // R7: synchronizer delay
    hwrite(3'd0, 16'h1111);
    @(negedge clk);
    host_addr = 3'd2; host_wdata = 16'h0003; host_ce = 1'b1; host_wr = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk($sformatf("R7 core_we after %0d edges", k), 32'(core_we), (k == 3) ? 1 : 0);
    end
    repeat (4) @(negedge clk);
    host_wr = 1'b0; repeat (4) @(negedge clk); host_ce = 1'b0;

    // R2 / R3: sweep of ordinary indices
    for (int a = 0; a < 32; a++) begin
      if (a == 10) continue;
      we0 = we_cnt;
      core_write(16'(a), pat(a, 0));
      chk("R2 one core write", 32'(we_cnt - we0), 1);
      chk("R2 write index", 32'(last_we_addr), 32'(a));
      chk("R2 write word", last_we_data, pat(a, 0));
    end
    for (int a = 0; a < 32; a++) begin
      if (a == 10) continue;
      re0 = re_cnt;
      core_read(16'(a), r32);
      chk("R3 readback", r32, pat(a, 0));
      chk("R3 one core read", 32'(re_cnt - re0), 1);
    end

    // R4: capture at selection only
    hwrite(3'd3, 16'd5);
    core_write(16'd5, 32'hCAFE_F00D);
    hread(3'd0, r16); chk("R4 stale lo", 32'(r16), 32'(pat(5, 0) & 32'hFFFF));
    hread(3'd1, r16); chk("R4 stale hi", 32'(r16), 32'(pat(5, 0) >> 16));
    hread(3'd0, r16); chk("R4 repeat lo", 32'(r16), 32'(pat(5, 0) & 32'hFFFF));
    core_read(16'd5, r32); chk("R4 reselect", r32, 32'hCAFE_F00D);

    // R11 / R5: hold flag and status layout
    core_write(16'h000A, 32'h0000_0001);
    hread(3'd3, r16); chk("R11 hold set", 32'(r16), 32'h1);
    ro_avail = 1'b1;
    hread(3'd3, r16); chk("R5 status avail+hold", 32'(r16), 32'h9);
    ro_avail = 1'b0;

    // R10: protected accesses with hold set
    for (int a = 0; a < 8; a++) core_write(16'h0100 + 16'(a), pat(a, 7));
    for (int a = 0; a < 8; a++) begin
      core_read(16'h0100 + 16'(a), r32);
      chk("R10 protected readback", r32, pat(a, 7));
    end

    // clear hold
    core_write(16'h000A, 32'h0000_0000);
    hread(3'd3, r16); chk("R11 hold cleared", 32'(r16), 0);

    // R8: protected writes dropped
    for (int a = 0; a < 4; a++) begin
      we0 = we_cnt;
      core_write(16'h0100 + 16'(a), 32'hDEAD_0000 | 32'(a));
      chk("R8 no core write", 32'(we_cnt - we0), 0);
      hread(3'd3, r16); chk("R8 denied bit", 32'(r16), 32'h4);
    end
    core_write(16'd3, 32'h0000_0033);
    hread(3'd3, r16); chk("R8 denied cleared", 32'(r16), 0);

    // R9: protected reads return zero
    for (int a = 0; a < 4; a++) begin
      re0 = re_cnt;
      core_read(16'h0100 + 16'(a), r32);
      chk("R9 zero readback", r32, 0);
      chk("R9 no core read", 32'(re_cnt - re0), 0);
    end

    // R8: stored values untouched, seen after hold set again
    core_write(16'h000A, 32'h0000_0001);
    for (int a = 0; a < 4; a++) begin
      core_read(16'h0100 + 16'(a), r32);
      chk("R8 value intact", r32, pat(a, 7));
    end

    // R6: stream reads
    we0 = we_cnt; re0 = re_cnt; pop0 = pop_cnt;
    hread(3'd2, r16); chk("R6 stream data", 32'(r16), 32'hBEEF);
    chk("R6 one pop", 32'(pop_cnt - pop0), 1);
    ro_data = 16'h1234;
    hread(3'd2, r16); chk("R6 stream data 2", 32'(r16), 32'h1234);
    chk("R6 two pops", 32'(pop_cnt - pop0), 2);
    chk("R6 no core access", 32'((we_cnt - we0) + (re_cnt - re0)), 0);

    // R12: chip enable low
    hwrite(3'd0, 16'h00AA);
    hwrite(3'd1, 16'h00BB);
    hwrite(3'd1, 16'h7777, 1'b0);
    we0 = we_cnt;
    hwrite(3'd2, 16'h0004, 1'b0);
    chk("R12 ce-low write ignored", 32'(we_cnt - we0), 0);
    hwrite(3'd2, 16'h0004);
    chk("R12 staged hi unchanged", last_we_data, 32'h00BB_00AA);
    @(negedge clk);
    host_addr = 3'd3; host_ce = 1'b0; host_rd = 1'b1;
    @(negedge clk); chk("R12 ce-low read zero", 32'(host_rdata), 0);
    host_ce = 1'b1; host_rd = 1'b0;
    @(negedge clk); chk("R12 rd-low read zero", 32'(host_rdata), 0);
    host_ce = 1'b0;

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule